// File: doc/BRIEF.md
# Three-Channel Timer Host Register Interface

This block is the byte-wide register front end for a bank of three 16-bit counters. A host writes configuration bytes to one shared control address and reads or writes count bytes at one address per counter. The block turns those byte accesses into per-counter load strobes with 16-bit load values, and into per-counter mode and access-type outputs. The counting logic sits elsewhere and feeds back its live count, its output pin level and a pulse that marks when it has taken in a newly loaded value.

The host can snapshot a running count without disturbing it. It does this with a single-counter latch command, or with a multi-counter read-back command that also freezes a status byte. Snapshots stay frozen until the host has read them out completely. The block tracks byte order per counter, so a two-byte access always goes low byte first, then high byte.

Top module: `tmr_host_if`

## Requirements
- R1: A write to address 3 with bits 7:6 = 0, 1 or 2 (target counter) and bits 5:4 nonzero configures that counter: bits 5:4 become its access type (01 low byte only, 10 high byte only, 11 low then high), bits 3:1 its mode and bit 0 its BCD flag; the `mode` and `acc` outputs show the new values from the cycle after the write. After reset every counter has access type 01, mode 0.
- R2: With access type 01, a write of byte B to the counter address gives `ld_val = {8'h00, B}` and a one-cycle `ld_stb` pulse in the cycle after the write.
- R3: With access type 10, a write of byte B gives `ld_val = {B, 8'h00}` and a one-cycle `ld_stb` pulse in the cycle after the write.
- R4: With access type 11, the first write is kept as the low byte and gives no strobe; the second write (byte H) gives `ld_val = {H, low byte}` and a strobe.
- R5: A configuration write resets that counter's write and read byte-order tracking, so the next byte in either direction is the low byte.
- R6: A read pulse on a counter address loads `rdata` in the following cycle with a byte of the live count, chosen by the access type; with type 11, successive reads alternate low byte then high byte. A read of address 3 returns 0.
- R7: A control write with bits 5:4 = 00 latches the target counter's live count. Reads then return bytes of that held value until every byte for the access type has been read. After that, reads follow the live count again.
- R8: While a counter's count or status is latched and not yet read, further latch requests for it have no effect.
- R9: A write to address 3 with bits 7:6 = 11 is a read-back command. Bits 3:1 select counters 0, 1 and 2 (bit 1 selects counter 0), and bit 5 = 0 latches the count of each selected counter.
- R10: In a read-back command, bit 4 = 0 latches a status byte for each selected counter, laid out as {OUT, null count, access type[1:0], mode[2:0], BCD}. The next read from that counter returns the status byte first, and the latched count follows it.
- R11: A counter's null-count flag is set by a configuration write and by every completed count load. It is cleared by that counter's `xfer_done` pulse, and a set in the same cycle wins. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| wdata | input | 8 | Write data byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| rd | input | 1 | Read strobe, one cycle per byte |
| live_cnt | input | 3x16 | Live count from each counter |
| out_pin | input | 3 | Output pin level of each counter |
| xfer_done | input | 3 | Pulse: counter has taken in its loaded value |
| rdata | output | 8 | Read data, valid the cycle after `rd` |
| ld_stb | output | 3 | One-cycle load strobe per counter |
| ld_val | output | 3x16 | Assembled load value per counter |
| mode | output | 3x3 | Programmed mode per counter |
| acc | output | 3x2 | Programmed access type per counter |

## Verification
The byte path is tried with each access type on a different counter. Writes show whether the byte lands in the low or the high half, and whether a lone first byte wrongly fires a strobe. A configuration write falls between the two bytes of a pair, which shows whether the byte-order tracking is reset. Latch tests change the live count after the snapshot, so the bench can tell a held value from a live one. A repeated latch and a multi-counter read-back that selects both count and status show whether a snapshot is overwritten and whether status comes out before count. A long random run then mixes configuration, latch, read-back, data and `xfer_done` traffic while the counts move every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_PAIR  = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } cfg_t;

    localparam logic [1:0] SEL_READBACK = 2'b11;
endpackage

// File: rtl/tmr_ctl_dec.sv
module tmr_ctl_dec
    import tmr_pkg::*;
#(
    parameter int NCNT = 3,
    parameter int AW   = 2
) (
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [7:0]      wdata,
    output logic [NCNT-1:0] cfg_we,
    output cfg_t            cfg_new,
    output logic [NCNT-1:0] lat_cnt,
    output logic [NCNT-1:0] lat_st
);
    timeunit 1ns;
    timeprecision 1ps;

    logic       ctl_hit;
    logic       is_rb;
    logic [1:0] sel;
    logic [1:0] rwf;

    assign ctl_hit = wr && (addr == AW'(NCNT));
    assign sel     = wdata[7:6];
    assign rwf     = wdata[5:4];
    assign is_rb   = (sel == SEL_READBACK);
    assign cfg_new = '{acc: acc_e'(rwf), mode: wdata[3:1], bcd: wdata[0]};

    for (genvar i = 0; i < NCNT; i++) begin : g_dec
        logic hit_one;
        logic rb_pick;
        assign hit_one    = ctl_hit && !is_rb && (sel == 2'(i));
        assign rb_pick    = ctl_hit && is_rb && wdata[1+i];
        assign cfg_we[i]  = hit_one && (rwf != 2'b00);
        assign lat_cnt[i] = (hit_one && (rwf == 2'b00)) || (rb_pick && !wdata[5]);
        assign lat_st[i]  = rb_pick && !wdata[4];
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter  int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  cfg_t          cfg_new,
    input  logic          lat_cnt,
    input  logic          lat_st,
    input  logic          wr_hit,
    input  logic          rd_hit,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] live,
    input  logic          out_pin,
    input  logic          xfer_done,
    output logic [DW-1:0] rbyte,
    output logic          ld_stb,
    output logic [CW-1:0] ld_val,
    output cfg_t          cfg_cur
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        cfg_t          cfg;
        logic          wtog;
        logic          rtog;
        logic [DW-1:0] lsb;
        logic          nul;
        logic          cl;
        logic [CW-1:0] hold;
        logic          sl;
        logic [DW-1:0] stat;
        logic          stb;
        logic [CW-1:0] ldv;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CW-1:0] src;
    logic [DW-1:0] stat_now;

    assign src      = st_q.cl ? st_q.hold : live;
    assign stat_now = DW'({out_pin, st_q.nul, st_q.cfg.acc, st_q.cfg.mode, st_q.cfg.bcd});

    always_comb begin
        if (st_q.sl) begin
            rbyte = st_q.stat;
        end else begin
            unique case (st_q.cfg.acc)
                ACC_HI:   rbyte = src[CW-1:DW];
                ACC_PAIR: rbyte = st_q.rtog ? src[CW-1:DW] : src[DW-1:0];
                default:  rbyte = src[DW-1:0];
            endcase
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (xfer_done) st_d.nul = 1'b0;

        if (rd_hit) begin
            if (st_q.sl) begin
                st_d.sl = 1'b0;
            end else if (st_q.cfg.acc == ACC_PAIR) begin
                st_d.rtog = !st_q.rtog;
                if (st_q.rtog) st_d.cl = 1'b0;
            end else begin
                st_d.cl = 1'b0;
            end
        end

        if (wr_hit) begin
            unique case (st_q.cfg.acc)
                ACC_HI: begin
                    st_d.ldv = {wdata, {DW{1'b0}}};
                    st_d.stb = 1'b1;
                end
                ACC_PAIR: begin
                    if (!st_q.wtog) begin
                        st_d.lsb  = wdata;
                        st_d.wtog = 1'b1;
                    end else begin
                        st_d.ldv  = {wdata, st_q.lsb};
                        st_d.stb  = 1'b1;
                        st_d.wtog = 1'b0;
                    end
                end
                default: begin
                    st_d.ldv = {{DW{1'b0}}, wdata};
                    st_d.stb = 1'b1;
                end
            endcase
        end
        if (st_d.stb) st_d.nul = 1'b1;

        if (lat_cnt && !st_q.cl) begin
            st_d.cl   = 1'b1;
            st_d.hold = live;
        end
        if (lat_st && !st_q.sl) begin
            st_d.sl   = 1'b1;
            st_d.stat = stat_now;
        end

        if (cfg_we) begin
            st_d.cfg  = cfg_new;
            st_d.wtog = 1'b0;
            st_d.rtog = 1'b0;
            st_d.nul  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cfg.acc <= ACC_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_stb  = st_q.stb;
    assign ld_val  = st_q.ldv;
    assign cfg_cur = st_q.cfg;

    assert_stb_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |-> $past(wr_hit));
    assert_pair_second_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stb && st_q.cfg.acc == ACC_PAIR) |-> $past(st_q.wtog));
    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cl && $past(st_q.cl)) |-> $stable(st_q.hold));
    assert_relatch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_st && st_q.sl) |=> $stable(st_q.stat));
    assert_status_before_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && st_q.sl && st_q.cl) |=> st_q.cl);
    assert_null_after_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> st_q.nul);
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter  int NCNT = 3,
    parameter  int DW   = 8,
    localparam int CW   = 2 * DW,
    localparam int AW   = $clog2(NCNT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [NCNT-1:0][CW-1:0]  live_cnt,
    input  logic [NCNT-1:0]          out_pin,
    input  logic [NCNT-1:0]          xfer_done,
    output logic [DW-1:0]            rdata,
    output logic [NCNT-1:0]          ld_stb,
    output logic [NCNT-1:0][CW-1:0]  ld_val,
    output logic [NCNT-1:0][2:0]     mode,
    output logic [NCNT-1:0][1:0]     acc
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NCNT-1:0]         cfg_we, lat_cnt, lat_st, wr_hit, rd_hit;
    logic [NCNT-1:0][DW-1:0] rbyte;
    cfg_t                    cfg_new;
    logic [DW-1:0]           rdata_d, rdata_q;

    tmr_ctl_dec #(.NCNT(NCNT), .AW(AW)) u_dec (
        .wr      (wr),
        .addr    (addr),
        .wdata   (wdata),
        .cfg_we  (cfg_we),
        .cfg_new (cfg_new),
        .lat_cnt (lat_cnt),
        .lat_st  (lat_st)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_ch
        cfg_t cfg_cur;
        assign wr_hit[i] = wr && (addr == AW'(i));
        assign rd_hit[i] = rd && (addr == AW'(i));
        tmr_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we[i]),
            .cfg_new   (cfg_new),
            .lat_cnt   (lat_cnt[i]),
            .lat_st    (lat_st[i]),
            .wr_hit    (wr_hit[i]),
            .rd_hit    (rd_hit[i]),
            .wdata     (wdata),
            .live      (live_cnt[i]),
            .out_pin   (out_pin[i]),
            .xfer_done (xfer_done[i]),
            .rbyte     (rbyte[i]),
            .ld_stb    (ld_stb[i]),
            .ld_val    (ld_val[i]),
            .cfg_cur   (cfg_cur)
        );
        assign mode[i] = cfg_cur.mode;
        assign acc[i]  = cfg_cur.acc;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            rdata_d = '0;
            for (int i = 0; i < NCNT; i++) begin
                if (rd_hit[i]) rdata_d = rbyte[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    assert_ctl_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == AW'(NCNT)) |=> (rdata == '0));
endmodule

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;
    timeunit 1ns;
    timeprecision 1ps;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        addr = '0;
    logic [7:0]        wdata = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [2:0][15:0]  live = '0;
    logic [2:0]        outp = '0;
    logic [2:0]        xfer = '0;
    logic [7:0]        rdata;
    logic [2:0]        ld_stb;
    logic [2:0][15:0]  ld_val;
    logic [2:0][2:0]   mode;
    logic [2:0][1:0]   acc;

    int checks = 0;
    int fails = 0;
    string tag = "R1";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_acc[3], m_mode[3], m_bcd[3], m_wtog[3], m_rtog[3], m_lsb[3];
    int m_nul[3], m_cl[3], m_hold[3], m_sl[3], m_stat[3], m_ldv[3], m_stb[3];
    int m_rd;

    always #2 clk = ~clk;

    tmr_host_if u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .live_cnt(live), .out_pin(outp), .xfer_done(xfer), .rdata(rdata),
        .ld_stb(ld_stb), .ld_val(ld_val), .mode(mode), .acc(acc)
    );

    function automatic int mbyte(int k);
        int src;
        if (m_sl[k] != 0) return m_stat[k];
        src = (m_cl[k] != 0) ? m_hold[k] : int'(live[k]);
        if (m_acc[k] == 2) return (src >> 8) & 255;
        if (m_acc[k] == 3 && m_rtog[k] != 0) return (src >> 8) & 255;
        return src & 255;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_acc[i] = 1; m_mode[i] = 0; m_bcd[i] = 0; m_wtog[i] = 0; m_rtog[i] = 0;
                m_lsb[i] = 0; m_nul[i] = 0; m_cl[i] = 0; m_hold[i] = 0; m_sl[i] = 0;
                m_stat[i] = 0; m_ldv[i] = 0; m_stb[i] = 0;
            end
            m_rd = 0;
        end else begin
            int w, sc, rwf, st;
            w = int'(wdata); sc = w >> 6; rwf = (w >> 4) & 3;
            for (int i = 0; i < 3; i++) m_stb[i] = 0;
            if (rd) begin
                if (addr == 2'd3) m_rd = 0;
                else begin
                    int k;
                    k = int'(addr);
                    m_rd = mbyte(k);
                    if (m_sl[k] != 0) m_sl[k] = 0;
                    else if (m_acc[k] == 3) begin
                        if (m_rtog[k] != 0) m_cl[k] = 0;
                        m_rtog[k] = (m_rtog[k] != 0) ? 0 : 1;
                    end else m_cl[k] = 0;
                end
            end
            for (int i = 0; i < 3; i++) begin
                st = (int'(outp[i]) << 7) | (m_nul[i] << 6) | (m_acc[i] << 4) | (m_mode[i] << 1) | m_bcd[i];
                if (xfer[i]) m_nul[i] = 0;
                if (wr && addr == 2'(i)) begin
                    if (m_acc[i] == 2) begin m_ldv[i] = w << 8; m_stb[i] = 1; end
                    else if (m_acc[i] == 3) begin
                        if (m_wtog[i] == 0) begin m_lsb[i] = w; m_wtog[i] = 1; end
                        else begin m_ldv[i] = (w << 8) | m_lsb[i]; m_stb[i] = 1; m_wtog[i] = 0; end
                    end else begin m_ldv[i] = w; m_stb[i] = 1; end
                    if (m_stb[i] != 0) m_nul[i] = 1;
                end
                if (wr && addr == 2'd3) begin
                    if (sc == i) begin
                        if (rwf == 0) begin
                            if (m_cl[i] == 0) begin m_cl[i] = 1; m_hold[i] = int'(live[i]); end
                        end else begin
                            m_acc[i] = rwf; m_mode[i] = (w >> 1) & 7; m_bcd[i] = w & 1;
                            m_wtog[i] = 0; m_rtog[i] = 0; m_nul[i] = 1;
                        end
                    end else if (sc == 3 && ((w >> (1 + i)) & 1) != 0) begin
                        if ((w & 32) == 0 && m_cl[i] == 0) begin m_cl[i] = 1; m_hold[i] = int'(live[i]); end
                        if ((w & 16) == 0 && m_sl[i] == 0) begin m_sl[i] = 1; m_stat[i] = st; end
                    end
                end
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            bit bad;
            bad = (int'(rdata) != m_rd);
            for (int i = 0; i < 3; i++) begin
                if (int'(ld_stb[i]) != m_stb[i] || int'(ld_val[i]) != m_ldv[i] ||
                    int'(mode[i]) != m_mode[i] || int'(acc[i]) != m_acc[i]) bad = 1'b1;
            end
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s model compare: actual rdata=%h stb=%b val=%h/%h/%h expected rdata=%h stb=%0d%0d%0d val=%h/%h/%h",
                         tag, rdata, ld_stb, ld_val[0], ld_val[1], ld_val[2], m_rd[7:0],
                         m_stb[2], m_stb[1], m_stb[0], m_ldv[0][15:0], m_ldv[1][15:0], m_ldv[2][15:0]);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(int a, int d);
        @(negedge clk); addr = 2'(a); wdata = 8'(d); wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic do_rd(int a, output int v);
        @(negedge clk); addr = 2'(a); rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = int'(rdata);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 reset rdata", int'(rdata), 0);
        chk("R1 reset ld_stb", int'(ld_stb), 0);
        chk("R1 reset acc0", int'(acc[0]), 1);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1 / R2: counter0 low-only, mode 2
        do_wr(3, 8'h14);
        chk("R1 mode0", int'(mode[0]), 2);
        chk("R1 acc0", int'(acc[0]), 1);
        tag = "R2";
        do_wr(0, 8'hA5);
        chk("R2 strobe", int'(ld_stb[0]), 1);
        chk("R2 value", int'(ld_val[0]), 16'h00A5);
        @(negedge clk);
        chk("R2 one-cycle strobe", int'(ld_stb[0]), 0);

        // R4: counter1 pair, mode 4, bcd
        tag = "R4";
        do_wr(3, 8'h79);
        do_wr(1, 8'h34);
        chk("R4 no strobe on first", int'(ld_stb[1]), 0);
        do_wr(1, 8'h12);
        chk("R4 strobe", int'(ld_stb[1]), 1);
        chk("R4 value", int'(ld_val[1]), 16'h1234);

        // R5: configuration between pair bytes
        tag = "R5";
        do_wr(1, 8'h56);
        do_wr(3, 8'h79);
        do_wr(1, 8'h78);
        chk("R5 toggle reset no strobe", int'(ld_stb[1]), 0);
        do_wr(1, 8'h9A);
        chk("R5 value", int'(ld_val[1]), 16'h9A78);

        // R3 / R6: counter2 high-only
        tag = "R3";
        do_wr(3, 8'hA0);
        do_wr(2, 8'h3C);
        chk("R3 value", int'(ld_val[2]), 16'h3C00);
        tag = "R6";
        live[2] = 16'h7E11;
        do_rd(2, v); chk("R6 live high byte", v, 8'h7E);
        live[1] = 16'hC0DE;
        do_rd(1, v); chk("R6 pair low", v, 8'hDE);
        do_rd(1, v); chk("R6 pair high", v, 8'hC0);
        do_rd(3, v); chk("R6 control read", v, 0);

        // R7: latch hold
        tag = "R7";
        live[1] = 16'hBEEF;
        do_wr(3, 8'h40);
        live[1] = 16'h0000;
        do_rd(1, v); chk("R7 held low", v, 8'hEF);
        do_rd(1, v); chk("R7 held high", v, 8'hBE);
        do_rd(1, v); chk("R7 live after release", v, 8'h00);
        do_rd(1, v);

        // R8: second latch ignored
        tag = "R8";
        live[1] = 16'h1111;
        do_wr(3, 8'h40);
        live[1] = 16'h2222;
        do_wr(3, 8'h40);
        do_rd(1, v); chk("R8 first latch kept low", v, 8'h11);
        do_rd(1, v); chk("R8 first latch kept high", v, 8'h11);

        // R9 / R10 / R11: read-back counter0 with status
        tag = "R10";
        live[0] = 16'hABCD;
        outp[0] = 1'b1;
        do_wr(3, 8'hC2);
        live[0] = 16'h5555;
        do_rd(0, v); chk("R10 status first", v, 8'hD4);
        tag = "R9";
        do_rd(0, v); chk("R9 latched count", v, 8'hCD);
        do_rd(0, v); chk("R9 live after", v, 8'h55);
        tag = "R11";
        @(negedge clk); xfer[0] = 1'b1;
        @(negedge clk); xfer[0] = 1'b0;
        do_wr(3, 8'hE2);
        do_rd(0, v); chk("R11 null cleared in status", v, 8'h94);
        do_wr(0, 8'h01);
        do_wr(3, 8'hE2);
        do_rd(0, v); chk("R11 null set by load", v, 8'hD4);

        // R9: all three, count only
        tag = "R9";
        live[0] = 16'h0102; live[1] = 16'h0304; live[2] = 16'h0506;
        do_wr(3, 8'hDE);
        live = '0;
        do_rd(0, v); chk("R9 multi ctr0", v, 8'h02);
        do_rd(2, v); chk("R9 multi ctr2", v, 8'h05);
        do_rd(1, v); chk("R9 multi ctr1 low", v, 8'h04);
        do_rd(1, v); chk("R9 multi ctr1 high", v, 8'h03);

        // random traffic against the model
        tag = "R1-random";
        for (int n = 0; n < 4000; n++) begin
            int r;
            @(negedge clk);
            r = int'($urandom % 8);
            wr = 1'b0; rd = 1'b0;
            live[0] = live[0] + 16'h0101;
            live[1] = live[1] - 16'h0013;
            live[2] = live[2] + 16'h1007;
            outp = 3'($urandom);
            xfer = 3'($urandom) & 3'($urandom);
            if (r == 0) begin addr = 2'd3; wdata = 8'($urandom); wr = 1'b1; end
            else if (r < 3) begin addr = 2'($urandom % 3); wdata = 8'($urandom); wr = 1'b1; end
            else if (r < 6) begin addr = 2'($urandom); rd = 1'b1; end
        end
        @(negedge clk); wr = 1'b0; rd = 1'b0; xfer = '0;
        @(negedge clk);
        finish_run();
    end
endmodule